// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block sequences the lights at a crossing of two roads, called A and B. Each road has a car sensor that is high while traffic is waiting or passing on that road. The controller is a four-phase Moore machine held in a two-bit register. The lights depend only on that register. A green phase lasts as long as its road's sensor stays high. Once the sensor drops, the road gets one cycle of yellow, and then the other road's green phase begins. Each clock cycle is one time step, and there is no separate dwell timer.

The phases are encoded A-green=00, A-yellow=01, B-green=10 and B-yellow=11. The next phase is found from two small equations: the high bit is the XOR of the two phase bits, and the low bit is set only by a green phase whose sensor is low. Each road's two-bit light code is decoded directly from the phase bits.

The reset input is asynchronous and active low. Asserting it forces road A to green and road B to red at once, without waiting for a clock. Releasing it passes through a short synchronizer, so the phase register leaves reset on a clock edge.

Top module: `crossing_light_ctrl`

## Requirements
- R1: While rst_n is low, a_light is 00 (green) and b_light is 10 (red). This takes effect as soon as rst_n falls, with no clock edge needed.
- R2: After rst_n rises, the phase stays at A-green for SYNC_STAGES (default 2) rising clock edges, whatever the sensors do. The first phase change can happen on the next edge after those.
- R3: In A-green (a_light=00, b_light=10), a rising edge with a_sense high keeps A-green.
- R4: In A-green, a rising edge with a_sense low moves to A-yellow, where a_light=01 and b_light=10.
- R5: A-yellow always moves to B-green (a_light=10, b_light=00) on the next edge. Both sensors are ignored.
- R6: In B-green, a rising edge with b_sense high keeps B-green.
- R7: In B-green, a rising edge with b_sense low moves to B-yellow, where a_light=10 and b_light=01.
- R8: B-yellow always moves to A-green on the next edge. Both sensors are ignored.
- R9: In every cycle at least one road shows red (10), and neither output ever shows code 11.
- R10: For any sequence of sensor values, the lights follow the four-phase sequence described in R3 to R8, cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one time step |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized |
| a_sense | input | 1 | High while cars are present on road A |
| b_sense | input | 1 | High while cars are present on road B |
| a_light | output | 2 | Road A light: 00 green, 01 yellow, 10 red |
| b_light | output | 2 | Road B light: 00 green, 01 yellow, 10 red |

## Verification
Two things can happen in the same cycle. A sensor can change while a yellow phase is ending, and a reset can arrive in the middle of a green phase. The bench raises or drops both sensors during each yellow cycle and checks, at the light outputs, that the next phase is still the other road's green. It also pulls rst_n low between clock edges while road B is green and checks that A-green appears before the next edge. A long pseudo-random sensor run is then compared cycle by cycle against a behavioural model of the phase sequence.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

  localparam int unsigned PHASE_W = 2;
  localparam int unsigned LAMP_W  = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_A_GO   = 2'b00,
    PH_A_WARN = 2'b01,
    PH_B_GO   = 2'b10,
    PH_B_WARN = 2'b11
  } phase_t;

  typedef enum logic [LAMP_W-1:0] {
    LAMP_GO   = 2'b00,
    LAMP_WARN = 2'b01,
    LAMP_STOP = 2'b10
  } lamp_t;

endpackage

// File: rtl/xlc_reset_sync.sv
module xlc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sync_rst_n
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign sync_rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/xlc_next_phase.sv
module xlc_next_phase
  import xlc_pkg::*;
(
  input  phase_t cur_phase,
  input  logic   a_sense,
  input  logic   b_sense,
  output phase_t nxt_phase
);

  logic hi_bit;
  logic lo_bit;
  logic nxt_hi;
  logic nxt_lo;

  always_comb begin
    hi_bit = cur_phase[1];
    lo_bit = cur_phase[0];
    // High bit advances through 00->01->10->11->00 pairs.
    nxt_hi = hi_bit ^ lo_bit;
    // Low bit set only when a green phase loses its traffic.
    nxt_lo = (~hi_bit & ~lo_bit & ~a_sense) |
             ( hi_bit & ~lo_bit & ~b_sense);
    nxt_phase = phase_t'({nxt_hi, nxt_lo});
  end

endmodule

// File: rtl/xlc_lamp_decode.sv
module xlc_lamp_decode
  import xlc_pkg::*;
#(
  parameter bit FOR_ROAD_B = 1'b0
) (
  input  phase_t             phase,
  output logic [LAMP_W-1:0]  lamp
);

  generate
    if (FOR_ROAD_B) begin : g_road_b
      // Red while A owns the crossing, yellow in B-warn.
      assign lamp = {~phase[1], phase[1] & phase[0]};
    end else begin : g_road_a
      // Red while B owns the crossing, yellow in A-warn.
      assign lamp = {phase[1], ~phase[1] & phase[0]};
    end
  endgenerate

endmodule

// File: rtl/crossing_light_ctrl.sv
module crossing_light_ctrl
  import xlc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sense,
  input  logic              b_sense,
  output logic [LAMP_W-1:0] a_light,
  output logic [LAMP_W-1:0] b_light
);

  logic   sys_rst_n;
  phase_t phase_q;
  phase_t phase_d;

  xlc_reset_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_rst_n (sys_rst_n)
  );

  xlc_next_phase u_next (
    .cur_phase (phase_q),
    .a_sense   (a_sense),
    .b_sense   (b_sense),
    .nxt_phase (phase_d)
  );

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      phase_q <= PH_A_GO;
    end else begin
      phase_q <= phase_d;
    end
  end

  xlc_lamp_decode #(
    .FOR_ROAD_B(1'b0)
  ) u_lamp_a (
    .phase (phase_q),
    .lamp  (a_light)
  );

  xlc_lamp_decode #(
    .FOR_ROAD_B(1'b1)
  ) u_lamp_b (
    .phase (phase_q),
    .lamp  (b_light)
  );

endmodule

// File: rtl/crossing_light_ctrl_chk.sv
module crossing_light_ctrl_chk
  import xlc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst_n,
  input logic              a_sense,
  input logic              b_sense,
  input logic [LAMP_W-1:0] a_light,
  input logic [LAMP_W-1:0] b_light
);

  localparam logic [LAMP_W-1:0] GO   = 2'b00;
  localparam logic [LAMP_W-1:0] WARN = 2'b01;
  localparam logic [LAMP_W-1:0] STOP = 2'b10;

  // R2: the synchronized reset window shows A-green.
  p_sync_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> (a_light == GO && b_light == STOP));

  // R3
  p_a_hold_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (a_light == GO && a_sense) |=> (a_light == GO && b_light == STOP));

  // R4
  p_a_exit_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (a_light == GO && !a_sense) |=> (a_light == WARN && b_light == STOP));

  // R5
  p_a_warn_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (a_light == WARN) |=> (a_light == STOP && b_light == GO));

  // R6
  p_b_hold_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (b_light == GO && b_sense) |=> (b_light == GO && a_light == STOP));

  // R7
  p_b_exit_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (b_light == GO && !b_sense) |=> (b_light == WARN && a_light == STOP));

  // R8
  p_b_warn_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (b_light == WARN) |=> (a_light == GO && b_light == STOP));

  // R9
  p_one_red_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (a_light == STOP || b_light == STOP) && a_light != 2'b11 && b_light != 2'b11);

endmodule

bind crossing_light_ctrl crossing_light_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_rst_n (sys_rst_n),
  .a_sense   (a_sense),
  .b_sense   (b_sense),
  .a_light   (a_light),
  .b_light   (b_light)
);

// File: tb/crossing_light_ctrl_test.sv
`timescale 1ns/100ps
module crossing_light_ctrl_test;

  localparam logic [1:0] L_GO = 2'b00, L_WARN = 2'b01, L_STOP = 2'b10;
  localparam int AGO = 0, AWARN = 1, BGO = 2, BWARN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       a_sense = 1'b0;
  logic       b_sense = 1'b0;
  logic [1:0] a_light;
  logic [1:0] b_light;

  int tests  = 0;
  int fails  = 0;
  int model  = AGO;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  crossing_light_ctrl uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_sense (a_sense),
    .b_sense (b_sense),
    .a_light (a_light),
    .b_light (b_light)
  );

  function automatic int model_next(int ph, logic a, logic b);
    case (ph)
      AGO:    return a ? AGO : AWARN;
      AWARN:  return BGO;
      BGO:    return b ? BGO : BWARN;
      default: return AGO;
    endcase
  endfunction

  function automatic logic [3:0] model_lamps(int ph);
    case (ph)
      AGO:    return {L_GO,   L_STOP};
      AWARN:  return {L_WARN, L_STOP};
      BGO:    return {L_STOP, L_GO};
      default: return {L_STOP, L_WARN};
    endcase
  endfunction

  task automatic check_lamps(input string tag);
    logic [3:0] exp;
    exp = model_lamps(model);
    tests++;
    if ({a_light, b_light} !== exp) begin
      fails++;
      $display("FAIL %s: lights a/b got %b/%b expected %b/%b",
               tag, a_light, b_light, exp[3:2], exp[1:0]);
    end
  endtask

  task automatic step(input logic a, input logic b, input string tag);
    @(negedge clk);
    a_sense = a;
    b_sense = b;
    @(posedge clk);
    model = model_next(model, a, b);
    #1;
    check_lamps(tag);
  endtask

  // Release reset with a low A sensor: two held edges, then A-warn.
  task automatic t_reset_release;
    @(negedge clk);
    rst_n   = 1'b0;
    a_sense = 1'b0;
    b_sense = 1'b1;
    repeat (3) @(negedge clk);
    model = AGO;
    check_lamps("R1 reset held");
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #1;
      check_lamps("R2 sync window");
    end
    step(1'b0, 1'b1, "R4 first move after release");
  endtask

  task automatic t_yellow_a;
    step(1'b1, 1'b1, "R5 A-warn ignores sensors");
  endtask

  task automatic t_hold_b;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R6 B-green hold");
  endtask

  task automatic t_exit_b;
    step(1'b1, 1'b0, "R7 B-green exit");
  endtask

  task automatic t_yellow_b;
    step(1'b0, 1'b1, "R8 B-warn ignores sensors");
  endtask

  task automatic t_hold_a;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R3 A-green hold");
  endtask

  task automatic t_exit_a;
    step(1'b0, 1'b1, "R4 A-green exit");
  endtask

  // Drop reset between edges while B is green; A-green must appear at once.
  task automatic t_async_reset;
    step(1'b1, 1'b1, "R5 into B-green");
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    model = AGO;
    #0.5;
    check_lamps("R1 asynchronous assert");
    repeat (2) @(negedge clk);
    a_sense = 1'b1;
    rst_n   = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #1;
      check_lamps("R2 sync window with sensor high");
    end
    step(1'b1, 1'b0, "R3 hold after release");
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic ra, rb;
      ra = 1'($urandom_range(0, 3) != 0);
      rb = 1'($urandom_range(0, 3) != 0);
      step(ra, rb, "R10 random sequence");
      tests++;
      if (!(a_light == L_STOP || b_light == L_STOP) ||
          a_light == 2'b11 || b_light == 2'b11) begin
        fails++;
        $display("FAIL R9: lights a/b got %b/%b expected one red, no 11",
                 a_light, b_light);
      end
    end
  endtask

  initial begin
    t_reset_release;
    t_yellow_a;
    t_hold_b;
    t_exit_b;
    t_yellow_b;
    t_hold_a;
    t_exit_a;
    t_yellow_a;
    t_exit_b;
    t_yellow_b;
    t_exit_a;
    t_async_reset;
    t_random;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run got hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule